// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the identity-selection stage of a single-wire bus slave. It works one bit slot at a time. A separate slot decoder tells it when a bus reset with its presence response has finished, when a bit written by the master has been received and what its value is, and when the master has opened a read slot. The block answers with the value the slave should put on the open-drain line during the next read slot. When an identity command finishes successfully, it raises a grant that passes the bus to the memory-function layer behind it.

The slave's 64-bit identity is built at elaboration time from two parameters, an 8-bit family code and a 48-bit serial number. An 8-bit CRC is computed over those 56 bits and placed in the top byte. The block supports five operations: sending the whole identity, matching an identity written by the master, skipping identification, and two bitwise arbitration searches. One search takes part unconditionally. The other takes part only while an unacknowledged interrupt is pending.

Top module: `ow_rom_layer`

## Requirements
- R1: The identity is ordered as family code in bits 7:0, serial number in bits 55:8 and CRC in bits 63:56. It is transmitted from bit 0 upward. The CRC register starts at zero and absorbs bits 0..55, one bit at a time, with the polynomial x^8+x^5+x^4+1 in shift-right form. After all 64 identity bits have been absorbed the register reads zero.
- R2: After rstN and after every reset strobe, the block collects an 8-bit command from received bits, first bit into bit 0. While it collects, grant is 0 and txBit is 1.
- R3: Command 33h makes each successive read slot return the next identity bit, starting at bit 0. Grant rises after the 64th read slot.
- R4: Command 55h compares 64 received bits against the identity. If every bit is equal, grant rises after the 64th bit.
- R5: During 55h, a received bit that differs from the identity puts the block in an idle state. In that state later bits and read slots have no effect, grant stays 0 and txBit stays 1 until the next reset strobe.
- R6: Command F0h runs three slots for each identity bit. The first read slot returns the bit, the second read slot returns its inverse, and then a bit is received from the master. If all 64 received bits equal the identity, grant rises.
- R7: During a search, a received choice bit that differs from the identity bit puts the block in the idle state of R5.
- R8: Command ECh behaves like F0h when irqPending is 1 at the eighth command bit. Otherwise it puts the block in the idle state.
- R9: Command CCh raises grant directly after the eighth command bit. Grant then stays high until a reset strobe.
- R10: Any command byte other than 33h, 55h, F0h, CCh or ECh puts the block in the idle state without raising grant.
- R11: txBit is 1 in every slot in which the block is not sending an identity bit or its inverse.
- R12: A reset strobe in any state, including partway through an operation or while grant is high, drops grant and starts a new command collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resetStrobe | input | 1 | One-cycle pulse: bus reset and presence response finished |
| bitValid | input | 1 | One-cycle pulse: a master-written bit was received |
| bitValue | input | 1 | Value of the received bit, valid with bitValid |
| readReq | input | 1 | One-cycle pulse: the master opened a read slot and is consuming txBit |
| irqPending | input | 1 | An unacknowledged interrupt is pending |
| txBit | output | 1 | Value to drive in the next read slot (1 releases the line) |
| grant | output | 1 | Control handed to the memory-function layer |

## Verification
Every strobe is taken on a single clock edge. The effect of a strobe on txBit and grant therefore appears exactly one cycle after that strobe, because the only register in the path is the state or index it updates. The bench drives each strobe for one cycle and leaves one quiet cycle after it. It reads txBit at the falling edge just before a read slot is pulsed, so the value it checks is the one the slot actually consumes. It reads grant at the falling edge after the final strobe of an operation.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int ID_W = BODY_W + CRC_W;
  localparam int CMD_W = 8;
  localparam logic [CRC_W-1:0] CRC_REFLECTED = 8'h8C;

  localparam logic [CMD_W-1:0] CODE_READ    = 8'h33;
  localparam logic [CMD_W-1:0] CODE_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] CODE_SEARCH  = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_SKIP    = 8'hCC;
  localparam logic [CMD_W-1:0] CODE_ISEARCH = 8'hEC;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_GRANT, ST_WAIT
  } romState_t;

  typedef struct packed {
    logic clrAll;
    logic cmdShift;
    logic idxInc;
    logic phaseInc;
    logic phaseClr;
  } dpCtl_t;

  function automatic logic [CRC_W-1:0] crcBits(input logic [ID_W-1:0] data, input int count);
    logic [CRC_W-1:0] reg8;
    logic fb;
    reg8 = '0;
    for (int i = 0; i < ID_W; i++) begin
      if (i < count) begin
        fb = reg8[0] ^ data[i];
        reg8 = reg8 >> 1;
        if (fb) reg8 = reg8 ^ CRC_REFLECTED;
      end
    end
    return reg8;
  endfunction
endpackage

// File: rtl/ow_rom_idpath.sv
module ow_rom_idpath
  import ow_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h00A1_B2C3_D4E5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             bitValue,
  output logic             idBit,
  output logic             idxLast,
  output logic [1:0]       phase,
  output logic             cmdLast,
  output logic [CMD_W-1:0] cmdNext
);
  localparam int IDX_W = $clog2(ID_W);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [BODY_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [CRC_W-1:0] ID_CRC = crcBits(ID_W'(BODY), BODY_W);
  localparam logic [ID_W-1:0] IDENT = {ID_CRC, BODY};

  logic [IDX_W-1:0] idx;
  logic [CMD_W-1:0] cmdSr;
  logic [CNT_W-1:0] cmdCnt;

  assign idBit   = IDENT[idx];
  assign idxLast = (idx == IDX_W'(ID_W - 1));
  assign cmdLast = (cmdCnt == CNT_W'(CMD_W - 1));
  assign cmdNext = {bitValue, cmdSr[CMD_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      phase  <= '0;
      cmdSr  <= '0;
      cmdCnt <= '0;
    end else if (ctl.clrAll) begin
      idx    <= '0;
      phase  <= '0;
      cmdSr  <= '0;
      cmdCnt <= '0;
    end else begin
      if (ctl.cmdShift) begin
        cmdSr  <= cmdNext;
        cmdCnt <= cmdCnt + 1'b1;
      end
      if (ctl.idxInc) idx <= idx + 1'b1;
      if (ctl.phaseClr) phase <= '0;
      else if (ctl.phaseInc) phase <= phase + 1'b1;
    end
  end

  initial begin
    AST_ID_CRC: assert (crcBits(IDENT, ID_W) == '0); // R1
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    phase != 2'd3); // R6
endmodule

// File: rtl/ow_rom_fsm.sv
module ow_rom_fsm
  import ow_rom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetStrobe,
  input  logic             bitValid,
  input  logic             bitValue,
  input  logic             readReq,
  input  logic             irqPending,
  input  logic             idBit,
  input  logic             idxLast,
  input  logic [1:0]       phase,
  input  logic             cmdLast,
  input  logic [CMD_W-1:0] cmdNext,
  output dpCtl_t           ctl,
  output logic             txBit,
  output logic             grant
);
  romState_t state, nxt;

  always_comb begin
    ctl = '0;
    nxt = state;
    if (resetStrobe) begin
      ctl.clrAll = 1'b1;
      nxt = ST_CMD;
    end else begin
      unique case (state)
        ST_CMD: if (bitValid) begin
          ctl.cmdShift = 1'b1;
          if (cmdLast) begin
            unique case (cmdNext)
              CODE_READ:    nxt = ST_READ;
              CODE_MATCH:   nxt = ST_MATCH;
              CODE_SEARCH:  nxt = ST_SEARCH;
              CODE_ISEARCH: nxt = irqPending ? ST_SEARCH : ST_WAIT;
              CODE_SKIP:    nxt = ST_GRANT;
              default:      nxt = ST_WAIT;
            endcase
          end
        end
        ST_READ: if (readReq) begin
          if (idxLast) nxt = ST_GRANT;
          else ctl.idxInc = 1'b1;
        end
        ST_MATCH: if (bitValid) begin
          if (bitValue != idBit) nxt = ST_WAIT;
          else if (idxLast) nxt = ST_GRANT;
          else ctl.idxInc = 1'b1;
        end
        ST_SEARCH: begin
          if (phase != 2'd2) begin
            if (readReq) ctl.phaseInc = 1'b1;
          end else if (bitValid) begin
            if (bitValue != idBit) nxt = ST_WAIT;
            else begin
              ctl.phaseClr = 1'b1;
              if (idxLast) nxt = ST_GRANT;
              else ctl.idxInc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    txBit = 1'b1;
    if (state == ST_READ) txBit = idBit;
    else if (state == ST_SEARCH && phase == 2'd0) txBit = idBit;
    else if (state == ST_SEARCH && phase == 2'd1) txBit = ~idBit;
  end

  assign grant = (state == ST_GRANT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CMD;
    else state <= nxt;
  end

  AST_RESET_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    resetStrobe |=> (state == ST_CMD && !grant)); // R12
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !resetStrobe) |=> (state == ST_WAIT && txBit && !grant)); // R5
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !resetStrobe) |=> grant); // R9
  AST_GRANT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(state) != ST_WAIT); // R10
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEARCH && phase == 2'd1 && !resetStrobe) |=>
      (state == ST_SEARCH && phase != 2'd0)); // R6
endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
  import ow_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h00A1_B2C3_D4E5
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetStrobe,
  input  logic bitValid,
  input  logic bitValue,
  input  logic readReq,
  input  logic irqPending,
  output logic txBit,
  output logic grant
);
  dpCtl_t ctl;
  logic idBit, idxLast, cmdLast;
  logic [1:0] phase;
  logic [CMD_W-1:0] cmdNext;

  ow_rom_idpath #(.FAMILY_CODE(FAMILY_CODE), .SERIAL_NUM(SERIAL_NUM)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitValue(bitValue),
    .idBit(idBit), .idxLast(idxLast), .phase(phase),
    .cmdLast(cmdLast), .cmdNext(cmdNext)
  );

  ow_rom_fsm uCtl (
    .clk(clk), .rstN(rstN), .resetStrobe(resetStrobe),
    .bitValid(bitValid), .bitValue(bitValue), .readReq(readReq),
    .irqPending(irqPending), .idBit(idBit), .idxLast(idxLast),
    .phase(phase), .cmdLast(cmdLast), .cmdNext(cmdNext),
    .ctl(ctl), .txBit(txBit), .grant(grant)
  );
endmodule

// File: tb/sim_ow_rom_layer.sv
module sim_ow_rom_layer;
  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetStrobe = 1'b0, bitValid = 1'b0, bitValue = 1'b0, readReq = 1'b0, irqPending = 1'b0;
  logic txBit, grant;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [63:0] ident;

  always #5 clk = ~clk;

  ow_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u0 (
    .clk(clk), .rstN(rstN), .resetStrobe(resetStrobe), .bitValid(bitValid),
    .bitValue(bitValue), .readReq(readReq), .irqPending(irqPending),
    .txBit(txBit), .grant(grant)
  );

  // explicit shift-register form of x^8+x^5+x^4+1, bits fed LSB first
  function automatic logic [7:0] crcFeed(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    logic f;
    for (int i = 0; i < n; i++) begin
      f = c[0] ^ d[i];
      c = {f, c[7], c[6], c[5], c[4] ^ f, c[3] ^ f, c[2], c[1]};
    end
    return c;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    resetStrobe = 1'b1; @(negedge clk); resetStrobe = 1'b0; @(negedge clk);
  endtask
  task automatic sendBit(input logic b);
    bitValue = b; bitValid = 1'b1; @(negedge clk); bitValid = 1'b0; @(negedge clk);
  endtask
  task automatic readBit(output logic b);
    b = txBit; readReq = 1'b1; @(negedge clk); readReq = 1'b0; @(negedge clk);
  endtask
  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic b, c;
    logic [63:0] got;
    ident[55:0] = {SER, FAM};
    ident[63:56] = crcFeed(ident, 56);
    chk(crcFeed(ident, 64), 64'h0, "R1 residue");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({grant, txBit}, 2'b01, "R2 reset state");

    // R3 read identity straight after rstN (no reset strobe)
    sendByte(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin readBit(b); got[i] = b; end
    chk(got, ident, "R1 R3 read identity");
    chk(grant, 1'b1, "R3 grant after read");
    chk(txBit, 1'b1, "R11 released in grant");

    // R12 reset during grant, then partway through a read
    pulseReset();
    chk({grant, txBit}, 2'b01, "R12 reset drops grant");
    sendByte(8'h33);
    for (int i = 0; i < 10; i++) readBit(b);
    pulseReset();
    sendByte(8'h33);
    chk(txBit, ident[0], "R12 fresh read restarts at bit0");

    // R4 full match
    pulseReset();
    sendByte(8'h55);
    for (int i = 0; i < 64; i++) begin
      chk(txBit, 1'b1, "R11 released during match");
      sendBit(ident[i]);
    end
    chk(grant, 1'b1, "R4 grant after match");

    // R5 mismatch at every position
    for (int k = 0; k < 64; k++) begin
      pulseReset();
      sendByte(8'h55);
      for (int i = 0; i < 64; i++) sendBit(i == k ? ~ident[i] : ident[i]);
      readBit(b);
      chk({grant, b}, 2'b01, "R5 match mismatch idles");
      sendByte(8'hCC);
      chk(grant, 1'b0, "R5 idle ignores later bits");
    end

    // R6 full search
    pulseReset();
    sendByte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      readBit(b); readBit(c);
      chk({b, c}, {ident[i], ~ident[i]}, "R6 bit and complement");
      chk(txBit, 1'b1, "R11 released awaiting choice");
      sendBit(ident[i]);
    end
    chk(grant, 1'b1, "R6 grant after search");

    // R7 dropout at every position
    for (int k = 0; k < 64; k++) begin
      pulseReset();
      sendByte(8'hF0);
      for (int i = 0; i <= k; i++) begin
        readBit(b); readBit(c);
        sendBit(i == k ? ~ident[i] : ident[i]);
      end
      readBit(b); readBit(c);
      chk({grant, b, c}, 3'b011, "R7 search dropout");
    end

    // R8 interrupt search
    irqPending = 1'b1;
    pulseReset();
    sendByte(8'hEC);
    for (int i = 0; i < 64; i++) begin
      readBit(b); readBit(c);
      chk({b, c}, {ident[i], ~ident[i]}, "R8 irq search slots");
      sendBit(ident[i]);
    end
    chk(grant, 1'b1, "R8 irq search grant");
    irqPending = 1'b0;
    pulseReset();
    sendByte(8'hEC);
    readBit(b); readBit(c);
    chk({grant, b, c}, 3'b011, "R8 no irq no participation");

    // R9 R10 sweep all command codes
    for (int code = 0; code < 256; code++) begin
      pulseReset();
      sendByte(8'(code));
      if (code == 8'hCC) chk(grant, 1'b1, "R9 skip grants");
      else chk(grant, 1'b0, "R10 no grant on command");
      if (code == 8'h33 || code == 8'hF0) chk(txBit, ident[0], "R3 R6 first bit ready");
      else chk(txBit, 1'b1, "R10 R11 released");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule